// File: doc/BRIEF.md
# SDRAM Command Timing Checker

This block sits beside an SDRAM command bus and only watches it. On every clock it samples the three active-low command strobes, the bank-select lines and the address bus. It decodes the command, keeps a small model of each bank, and tests the command against the minimum spacing rules and the bank-state rules of a synchronous DRAM.

The bank model holds whether the bank is idle or has a row open. It also keeps three saturating cycle counters per bank: cycles since the last activate, since the last precharge and since the last write command. Two counters are shared by all banks: cycles since the last mode-register load and cycles since the last activate to any bank, together with the bank that activate went to.

The first violation latches a sticky error flag and a code that names the broken rule. Every timing limit is a parameter. The checker drives nothing onto the bus and does not look at data, latency or bursts.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: The command is `{ras_n, cas_n, we_n}` sampled at a rising clock edge, decoded as follows. 3'b000 is mode load, 3'b001 is refresh and 3'b010 is precharge. 3'b011 is activate, 3'b100 is write and 3'b101 is read. 3'b110 is burst stop and 3'b111 is no-operation.
- R2: The first violation sets `err_flag` and loads `err_code` one cycle after the offending command. Both then hold, unchanged by later violations, until `rst`. `err_code` is 0 whenever `err_flag` is low.
- R3: A synchronous `rst` clears the flag and sets the code to 0. It makes every bank idle and treats all timers as long expired, so an activate right after reset is legal.
- R4: A read or write to an idle bank gives code 1. An activate to a bank that already has an open row gives code 2.
- R5: A refresh while any bank is open gives code 3.
- R6: Any command other than no-operation that comes fewer than T_MRD cycles after a mode load gives code 4.
- R7: A read or write to a bank fewer than T_RCD cycles after that bank's activate gives code 5.
- R8: An activate to a bank fewer than T_RC cycles after that bank's previous activate gives code 6.
- R9: An activate fewer than T_RRD cycles after an activate to a different bank gives code 7.
- R10: An activate to a bank fewer than T_RP cycles after that bank was precharged gives code 8. A refresh fewer than T_RP cycles after any bank was precharged also gives code 8.
- R11: A precharge that closes a bank fewer than T_WR cycles after a write command to that bank gives code 9.
- R12: A precharge with address bit 10 high closes every bank. With bit 10 low it closes only the bank on `ba`, and the other banks stay open.
- R13: If one command breaks several rules, the lowest code is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all sampling on rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BANK_W | Bank select |
| addr | input | ADDR_W | Row/column address; bit 10 is the all-banks select on precharge |
| err_flag | output | 1 | Sticky violation flag |
| err_code | output | 4 | Code of the first violated rule (R4 to R11) |

## Verification
Some rules can only be tested once the bus is in a long, specific state. One case is a precharge-all arriving while a write-recovery window is still open on a bank other than the one on `ba`. Another is an activate that meets the same-bank precharge gap but comes one cycle short of the same-bank activate cycle time. Directed sequences set up these states by counting no-operation slots exactly, each run both at the limit and one cycle before it. Seeded random command streams with gaps of 0 to 6 slots then sweep the same boundaries across banks. A bench model that keeps absolute time stamps predicts the flag and the code after every command.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;

    typedef enum logic [2:0] {
        CMD_MRS = 3'b000,
        CMD_REF = 3'b001,
        CMD_PRE = 3'b010,
        CMD_ACT = 3'b011,
        CMD_WR  = 3'b100,
        CMD_RD  = 3'b101,
        CMD_BST = 3'b110,
        CMD_NOP = 3'b111
    } sdram_cmd_e;

    typedef enum logic [3:0] {
        ERR_NONE      = 4'd0,
        ERR_IDLE_RW   = 4'd1,
        ERR_OPEN_ACT  = 4'd2,
        ERR_REF_OPEN  = 4'd3,
        ERR_MRD       = 4'd4,
        ERR_RCD       = 4'd5,
        ERR_RC        = 4'd6,
        ERR_RRD       = 4'd7,
        ERR_RP        = 4'd8,
        ERR_WR        = 4'd9
    } mon_err_e;

    localparam int NUM_RULES = 9;

endpackage

// File: rtl/sdram_mon_decode.sv
module sdram_mon_decode
    import sdram_mon_pkg::*;
(
    input  logic       ras_n,
    input  logic       cas_n,
    input  logic       we_n,
    output sdram_cmd_e cmd,
    output logic       is_act,
    output logic       is_pre,
    output logic       is_rd,
    output logic       is_wr,
    output logic       is_ref,
    output logic       is_mrs,
    output logic       is_nop
);

    always_comb begin
        cmd    = sdram_cmd_e'({ras_n, cas_n, we_n});
        is_act = (cmd == CMD_ACT);
        is_pre = (cmd == CMD_PRE);
        is_rd  = (cmd == CMD_RD);
        is_wr  = (cmd == CMD_WR);
        is_ref = (cmd == CMD_REF);
        is_mrs = (cmd == CMD_MRS);
        is_nop = (cmd == CMD_NOP);
    end

endmodule

// File: rtl/sdram_mon_bank.sv
module sdram_mon_bank #(
    parameter int CNT_W = 4,
    parameter int T_RCD = 3,
    parameter int T_RC  = 8,
    parameter int T_RP  = 3,
    parameter int T_WR  = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sel,
    input  logic pre_all,
    input  logic is_act,
    input  logic is_pre,
    input  logic is_wr,
    output logic open_o,
    output logic rcd_ok,
    output logic rc_ok,
    output logic rp_ok,
    output logic wr_ok
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic             open;
        logic [CNT_W-1:0] act_cnt;
        logic [CNT_W-1:0] pre_cnt;
        logic [CNT_W-1:0] wr_cnt;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.act_cnt != CNT_MAX) st_d.act_cnt = st_q.act_cnt + CNT_ONE;
        if (st_q.pre_cnt != CNT_MAX) st_d.pre_cnt = st_q.pre_cnt + CNT_ONE;
        if (st_q.wr_cnt  != CNT_MAX) st_d.wr_cnt  = st_q.wr_cnt  + CNT_ONE;
        if (is_act && sel) begin
            st_d.open    = 1'b1;
            st_d.act_cnt = CNT_ONE;
        end
        if (is_pre && (sel || pre_all)) begin
            st_d.open    = 1'b0;
            st_d.pre_cnt = CNT_ONE;
        end
        if (is_wr && sel) begin
            st_d.wr_cnt = CNT_ONE;
        end
        if (rst) begin
            st_d.open    = 1'b0;
            st_d.act_cnt = CNT_MAX;
            st_d.pre_cnt = CNT_MAX;
            st_d.wr_cnt  = CNT_MAX;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign open_o = st_q.open;
    assign rcd_ok = (st_q.act_cnt >= CNT_W'(T_RCD));
    assign rc_ok  = (st_q.act_cnt >= CNT_W'(T_RC));
    assign rp_ok  = (st_q.pre_cnt >= CNT_W'(T_RP));
    assign wr_ok  = (st_q.wr_cnt  >= CNT_W'(T_WR));

endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
    import sdram_mon_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int ADDR_W = 13,
    parameter int T_RCD  = 3,
    parameter int T_RC   = 8,
    parameter int T_RRD  = 3,
    parameter int T_RP   = 3,
    parameter int T_WR   = 2,
    parameter int T_MRD  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [BANK_W-1:0] ba,
    input  logic [ADDR_W-1:0] addr,
    output logic              err_flag,
    output logic [3:0]        err_code
);

    localparam int NUM_BANKS = 1 << BANK_W;
    localparam int A10_BIT   = 10;
    localparam int T_M1 = (T_RCD > T_RC) ? T_RCD : T_RC;
    localparam int T_M2 = (T_RRD > T_RP) ? T_RRD : T_RP;
    localparam int T_M3 = (T_WR > T_MRD) ? T_WR : T_MRD;
    localparam int T_M4 = (T_M1 > T_M2) ? T_M1 : T_M2;
    localparam int T_MAX = (T_M4 > T_M3) ? T_M4 : T_M3;
    localparam int CNT_W = $clog2(T_MAX + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic              flag;
        mon_err_e          code;
        logic [CNT_W-1:0]  mrd_cnt;
        logic [CNT_W-1:0]  rrd_cnt;
        logic [BANK_W-1:0] last_bank;
    } mon_st_t;

    mon_st_t st_d, st_q;

    sdram_cmd_e cmd;
    logic is_act, is_pre, is_rd, is_wr, is_ref, is_mrs, is_nop;
    logic a10;
    logic addr_unused;

    logic [NUM_BANKS-1:0] bank_open;
    logic [NUM_BANKS-1:0] rcd_ok;
    logic [NUM_BANKS-1:0] rc_ok;
    logic [NUM_BANKS-1:0] rp_ok;
    logic [NUM_BANKS-1:0] wr_ok;
    logic [NUM_BANKS-1:0] pre_mask;
    logic [NUM_RULES:1]   viol;
    mon_err_e             first_err;

    assign a10         = addr[A10_BIT];
    assign addr_unused = ^addr;

    sdram_mon_decode u_decode (
        .ras_n  (ras_n),
        .cas_n  (cas_n),
        .we_n   (we_n),
        .cmd    (cmd),
        .is_act (is_act),
        .is_pre (is_pre),
        .is_rd  (is_rd),
        .is_wr  (is_wr),
        .is_ref (is_ref),
        .is_mrs (is_mrs),
        .is_nop (is_nop)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        sdram_mon_bank #(
            .CNT_W (CNT_W),
            .T_RCD (T_RCD),
            .T_RC  (T_RC),
            .T_RP  (T_RP),
            .T_WR  (T_WR)
        ) u_bank (
            .clk     (clk),
            .rst     (rst),
            .sel     (ba == BANK_W'(b)),
            .pre_all (a10),
            .is_act  (is_act),
            .is_pre  (is_pre),
            .is_wr   (is_wr),
            .open_o  (bank_open[b]),
            .rcd_ok  (rcd_ok[b]),
            .rc_ok   (rc_ok[b]),
            .rp_ok   (rp_ok[b]),
            .wr_ok   (wr_ok[b])
        );
    end

    always_comb begin
        pre_mask = '0;
        pre_mask[ba] = 1'b1;
        if (a10) pre_mask = '1;

        viol = '0;
        viol[1] = (is_rd || is_wr) && !bank_open[ba];
        viol[2] = is_act && bank_open[ba];
        viol[3] = is_ref && (|bank_open);
        viol[4] = !is_nop && (st_q.mrd_cnt < CNT_W'(T_MRD));
        viol[5] = (is_rd || is_wr) && !rcd_ok[ba];
        viol[6] = is_act && !rc_ok[ba];
        viol[7] = is_act && (st_q.last_bank != ba) && (st_q.rrd_cnt < CNT_W'(T_RRD));
        viol[8] = (is_act && !rp_ok[ba]) || (is_ref && !(&rp_ok));
        viol[9] = is_pre && (|(pre_mask & ~wr_ok));

        first_err = ERR_NONE;
        for (int i = NUM_RULES; i >= 1; i--) begin
            if (viol[i]) first_err = mon_err_e'(4'(i));
        end
    end

    always_comb begin
        st_d = st_q;
        if (st_q.mrd_cnt != CNT_MAX) st_d.mrd_cnt = st_q.mrd_cnt + CNT_ONE;
        if (st_q.rrd_cnt != CNT_MAX) st_d.rrd_cnt = st_q.rrd_cnt + CNT_ONE;
        if (is_mrs) st_d.mrd_cnt = CNT_ONE;
        if (is_act) begin
            st_d.rrd_cnt   = CNT_ONE;
            st_d.last_bank = ba;
        end
        if (!st_q.flag && (first_err != ERR_NONE)) begin
            st_d.flag = 1'b1;
            st_d.code = first_err;
        end
        if (rst) begin
            st_d.flag      = 1'b0;
            st_d.code      = ERR_NONE;
            st_d.mrd_cnt   = CNT_MAX;
            st_d.rrd_cnt   = CNT_MAX;
            st_d.last_bank = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign err_flag = st_q.flag;
    assign err_code = st_q.code;

endmodule

// File: rtl/sdram_cmd_monitor_chk.sv
module sdram_cmd_monitor_chk
    import sdram_mon_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BANK_W    = 2
) (
    input logic                 clk,
    input logic                 rst,
    input sdram_cmd_e           cmd,
    input logic [BANK_W-1:0]    ba,
    input logic                 a10,
    input logic [NUM_BANKS-1:0] bank_open,
    input logic                 err_flag,
    input logic [3:0]           err_code
);

    // R2
    sticky_flag_chk: assert property (@(posedge clk) disable iff (rst)
        err_flag |=> (err_flag && $stable(err_code)));

    // R2
    code_zero_when_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !err_flag |-> (err_code == 4'd0));

    // R3
    reset_clears_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!err_flag && bank_open == '0));

    // R4
    idle_access_chk: assert property (@(posedge clk) disable iff (rst)
        ((cmd == CMD_RD || cmd == CMD_WR) && !bank_open[ba]) |=> err_flag);

    // R5
    refresh_open_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_REF && (|bank_open)) |=> err_flag);

    // R12
    precharge_all_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_PRE && a10) |=> (bank_open == '0));

    // R12
    precharge_one_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_PRE && !a10) |=> !bank_open[$past(ba)]);

endmodule

bind sdram_cmd_monitor sdram_cmd_monitor_chk #(
    .NUM_BANKS (NUM_BANKS),
    .BANK_W    (BANK_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd       (cmd),
    .ba        (ba),
    .a10       (addr[10]),
    .bank_open (bank_open),
    .err_flag  (err_flag),
    .err_code  (err_code)
);

// File: tb/test_sdram_cmd_monitor.sv
module test_sdram_cmd_monitor;
    import sdram_mon_pkg::*;

    localparam int BANK_W = 2;
    localparam int NB     = 1 << BANK_W;
    localparam int ADDR_W = 13;
    localparam int T_RCD  = 3;
    localparam int T_RC   = 8;
    localparam int T_RRD  = 3;
    localparam int T_RP   = 3;
    localparam int T_WR   = 2;
    localparam int T_MRD  = 3;
    localparam int LONG_AGO = -1000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [BANK_W-1:0] ba = '0;
    logic [ADDR_W-1:0] addr = '0;
    logic              err_flag;
    logic [3:0]        err_code;

    int n_chk = 0;
    int n_fail = 0;
    int slot = 0;
    bit finished = 1'b0;

    // reference model state: absolute slot stamps
    int t_act[NB];
    int t_pre[NB];
    int t_wr[NB];
    bit op[NB];
    int t_actany, act_bank, t_mrs;
    bit m_flag;
    int m_code;

    always #10 clk = ~clk;

    sdram_cmd_monitor #(
        .BANK_W (BANK_W), .ADDR_W (ADDR_W),
        .T_RCD (T_RCD), .T_RC (T_RC), .T_RRD (T_RRD),
        .T_RP (T_RP), .T_WR (T_WR), .T_MRD (T_MRD)
    ) i_sdram_cmd_monitor (
        .clk (clk), .rst (rst),
        .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n),
        .ba (ba), .addr (addr),
        .err_flag (err_flag), .err_code (err_code)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic void model_reset();
        for (int i = 0; i < NB; i++) begin
            t_act[i] = LONG_AGO; t_pre[i] = LONG_AGO; t_wr[i] = LONG_AGO; op[i] = 1'b0;
        end
        t_actany = LONG_AGO; act_bank = -1; t_mrs = LONG_AGO;
        m_flag = 1'b0; m_code = 0;
    endfunction

    function automatic int predict(sdram_cmd_e c, int b, bit a10);
        bit rw = (c == CMD_RD) || (c == CMD_WR);
        bit any_open = 1'b0;
        for (int i = 0; i < NB; i++) any_open |= op[i];
        if (rw && !op[b]) return 1;
        if (c == CMD_ACT && op[b]) return 2;
        if (c == CMD_REF && any_open) return 3;
        if (c != CMD_NOP && slot - t_mrs < T_MRD) return 4;
        if (rw && slot - t_act[b] < T_RCD) return 5;
        if (c == CMD_ACT && slot - t_act[b] < T_RC) return 6;
        if (c == CMD_ACT && act_bank != b && slot - t_actany < T_RRD) return 7;
        if (c == CMD_ACT && slot - t_pre[b] < T_RP) return 8;
        if (c == CMD_REF)
            for (int i = 0; i < NB; i++) if (slot - t_pre[i] < T_RP) return 8;
        if (c == CMD_PRE)
            for (int i = 0; i < NB; i++)
                if ((a10 || i == b) && slot - t_wr[i] < T_WR) return 9;
        return 0;
    endfunction

    function automatic void model_update(sdram_cmd_e c, int b, bit a10);
        case (c)
            CMD_ACT: begin op[b] = 1'b1; t_act[b] = slot; t_actany = slot; act_bank = b; end
            CMD_PRE: for (int i = 0; i < NB; i++)
                         if (a10 || i == b) begin op[i] = 1'b0; t_pre[i] = slot; end
            CMD_WR:  t_wr[b] = slot;
            CMD_MRS: t_mrs = slot;
            default: ;
        endcase
    endfunction

    task automatic step(input sdram_cmd_e c, input int b, input bit a10, input string req);
        int e;
        @(negedge clk);
        e = predict(c, b, a10);
        if (!m_flag && e != 0) begin m_flag = 1'b1; m_code = e; end
        model_update(c, b, a10);
        {ras_n, cas_n, we_n} = c;
        ba = b[BANK_W-1:0];
        addr = ADDR_W'($urandom);
        addr[10] = a10;
        slot++;
        @(posedge clk); #1;
        check(req, "err_flag", int'(err_flag), int'(m_flag));
        check(req, "err_code", int'(err_code), m_code);
    endtask

    task automatic nops(input int n);
        for (int i = 0; i < n; i++) step(CMD_NOP, 0, 1'b0, "R1");
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        {ras_n, cas_n, we_n} = CMD_NOP;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        #1;
        check("R3", "err_flag after reset", int'(err_flag), 0);
        check("R3", "err_code after reset", int'(err_code), 0);
    endtask

    task automatic expect_code(input string req, input int exp);
        check(req, "final err_code", int'(err_code), exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(posedge clk);
        do_reset();

        // R3: activate straight after reset is legal
        step(CMD_ACT, 0, 1'b0, "R3");
        expect_code("R3", 0);

        // R4: access to idle bank
        do_reset();
        step(CMD_RD, 1, 1'b0, "R4");
        expect_code("R4", 1);
        // R13: activate to open bank also too early for tRC -> lower code
        do_reset();
        step(CMD_ACT, 0, 1'b0, "R13");
        nops(2);
        step(CMD_ACT, 0, 1'b0, "R13");
        expect_code("R13", 2);
        // R2: later violation does not replace the code
        step(CMD_WR, 3, 1'b0, "R2");
        expect_code("R2", 2);

        // R5
        do_reset();
        step(CMD_ACT, 2, 1'b0, "R5");
        nops(4);
        step(CMD_REF, 0, 1'b0, "R5");
        expect_code("R5", 3);

        // R6 limit and one short
        do_reset();
        step(CMD_MRS, 0, 1'b0, "R6"); nops(T_MRD - 1); step(CMD_ACT, 0, 1'b0, "R6");
        expect_code("R6", 0);
        do_reset();
        step(CMD_MRS, 0, 1'b0, "R6"); nops(T_MRD - 2); step(CMD_ACT, 0, 1'b0, "R6");
        expect_code("R6", 4);

        // R7
        do_reset();
        step(CMD_ACT, 1, 1'b0, "R7"); nops(T_RCD - 1); step(CMD_RD, 1, 1'b0, "R7");
        expect_code("R7", 0);
        do_reset();
        step(CMD_ACT, 1, 1'b0, "R7"); nops(T_RCD - 2); step(CMD_WR, 1, 1'b0, "R7");
        expect_code("R7", 5);

        // R8: ACT, PRE at T_RCD, re-ACT at T_RC-1 / T_RC
        do_reset();
        step(CMD_ACT, 0, 1'b0, "R8"); nops(T_RCD - 1); step(CMD_PRE, 0, 1'b0, "R8");
        nops(T_RC - T_RCD - 1); step(CMD_ACT, 0, 1'b0, "R8");
        expect_code("R8", 0);
        do_reset();
        step(CMD_ACT, 0, 1'b0, "R8"); nops(T_RCD - 1); step(CMD_PRE, 0, 1'b0, "R8");
        nops(T_RC - T_RCD - 2); step(CMD_ACT, 0, 1'b0, "R8");
        expect_code("R8", 6);

        // R9
        do_reset();
        step(CMD_ACT, 0, 1'b0, "R9"); nops(T_RRD - 1); step(CMD_ACT, 1, 1'b0, "R9");
        expect_code("R9", 0);
        do_reset();
        step(CMD_ACT, 0, 1'b0, "R9"); nops(T_RRD - 2); step(CMD_ACT, 1, 1'b0, "R9");
        expect_code("R9", 7);

        // R10: activate and refresh after precharge
        do_reset();
        step(CMD_PRE, 2, 1'b0, "R10"); nops(T_RP - 1); step(CMD_ACT, 2, 1'b0, "R10");
        expect_code("R10", 0);
        do_reset();
        step(CMD_PRE, 2, 1'b0, "R10"); nops(T_RP - 2); step(CMD_ACT, 2, 1'b0, "R10");
        expect_code("R10", 8);
        do_reset();
        step(CMD_PRE, 0, 1'b1, "R10"); nops(T_RP - 2); step(CMD_REF, 0, 1'b0, "R10");
        expect_code("R10", 8);

        // R11: write recovery, single bank and via all-banks precharge
        do_reset();
        step(CMD_ACT, 1, 1'b0, "R11"); nops(T_RCD - 1); step(CMD_WR, 1, 1'b0, "R11");
        nops(T_WR - 1); step(CMD_PRE, 1, 1'b0, "R11");
        expect_code("R11", 0);
        do_reset();
        step(CMD_ACT, 1, 1'b0, "R11"); nops(T_RCD - 1); step(CMD_WR, 1, 1'b0, "R11");
        nops(T_WR - 2); step(CMD_PRE, 1, 1'b0, "R11");
        expect_code("R11", 9);
        do_reset();
        step(CMD_ACT, 1, 1'b0, "R11"); nops(T_RCD - 1); step(CMD_WR, 1, 1'b0, "R11");
        nops(T_WR - 2); step(CMD_PRE, 3, 1'b1, "R11");
        expect_code("R11", 9);

        // R12: bit 10 low closes only the addressed bank
        do_reset();
        step(CMD_ACT, 0, 1'b0, "R12"); nops(T_RRD - 1); step(CMD_ACT, 1, 1'b0, "R12");
        nops(T_RCD); step(CMD_PRE, 0, 1'b0, "R12");
        step(CMD_RD, 1, 1'b0, "R12");
        expect_code("R12", 0);
        step(CMD_RD, 0, 1'b0, "R12");
        expect_code("R12", 1);
        // R12: bit 10 high closes all
        do_reset();
        step(CMD_ACT, 0, 1'b0, "R12"); nops(T_RRD - 1); step(CMD_ACT, 1, 1'b0, "R12");
        nops(T_RCD); step(CMD_PRE, 0, 1'b1, "R12");
        step(CMD_RD, 1, 1'b0, "R12");
        expect_code("R12", 1);

        // R2 / R1: seeded random streams checked against the model
        for (int run = 0; run < 150; run++) begin
            do_reset();
            for (int k = 0; k < 14; k++) begin
                int r = $urandom_range(0, 11);
                sdram_cmd_e c;
                if (r < 8) c = sdram_cmd_e'(3'(r));
                else if (r < 10) c = CMD_ACT;
                else c = (r == 10) ? CMD_RD : CMD_WR;
                step(c, $urandom_range(0, NB - 1), 1'($urandom_range(0, 1)), "R2");
                nops($urandom_range(0, 6));
            end
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule